// File: doc/BRIEF.md
# General-Purpose Timer Channel with Capture and PWM

This block is one 32-bit timer channel. An 8-bit mode register chooses what the channel does. It can count once or repeatedly, in either direction, and it can compare its count against a match value to raise an interrupt. It can also start only after a trigger from an upstream channel, and it can freeze the count at each time-out so that software reads a stable value. The same counter serves two capture modes, one that counts input edges and one that timestamps them, and a PWM mode that drives a waveform pin.

Software uses a small register port. It writes the reload and match values, sets the mode while the channel is stopped, and then sets the enable bit. Three sticky interrupt flags report time-outs, matches and capture events; writing ones to the clear register drops them. A one-cycle trigger pulse at each time-out can start the next channel in a chain.

Register map (word addresses on `wr_addr`/`rd_addr`): 0 control (bit 0 enable), 1 mode, 2 reload, 3 match, 4 value (read only), 5 capture (read only), 6 flags (read only; bit 0 time-out, bit 1 match, bit 2 capture), 7 flag clear (write only). Mode byte: bits 1:0 kind (1 one-shot, 2 periodic, 3 capture, 0 idle), bit 2 capture style (0 edge count, 1 edge time), bit 3 alternate function (1 PWM), bit 4 up-count, bit 5 match-interrupt enable, bit 6 wait for chain trigger, bit 7 snapshot.

Top module: `gp_timer_chan`

## Requirements
- R1: After reset every readable register reads zero, and `trig_out`, `pwm_out` and the three interrupt outputs are low.
- R2: The mode register (address 1) reads back bits 7:0 of the last accepted write, with bits 31:8 zero. A write to it while enable is set is ignored.
- R3: One-shot down-count (mode kind 1, bit 4 clear) loads the reload value on enable and decrements once per cycle. On the cycle after the count is 0, it sets the time-out flag (flags bit 0), clears enable and keeps the count at 0.
- R4: Periodic up-count (kind 2, bit 4 set) starts at 0 and increments to the reload value. The next cycle restarts it at 0 and sets the time-out flag, so time-outs recur every reload+1 cycles.
- R5: Each time-out drives `trig_out` high for exactly one cycle.
- R6: With mode bit 6 set, the enabled count holds at its start value until `trig_in` is seen high. It then advances, one cycle after that sample.
- R7: With mode bit 5 set, the match flag (flags bit 1) is set one cycle after a running timer's count equals the match value. With bit 5 clear the match flag is never set by the timer.
- R8: With mode bit 7 set in periodic mode, the value register (address 4) returns the count latched at the latest time-out instead of the live count.
- R9: Edge-count capture (kind 3, bits 2 and 3 clear) starts from the reload value. The count drops by one for each rising edge of `cap_in`. When the new value would equal the match value, the capture flag (flags bit 2) is set and the count returns to the reload value.
- R10: Edge-time capture (kind 3, bit 2 set, bit 3 clear) counts down from the reload value, wrapping back to it after 0. Each rising edge of `cap_in` latches the count into the capture register (address 5) and sets the capture flag. Two edges N cycles apart latch values that differ by N.
- R11: PWM runs only when bit 3 is set, bit 2 is clear and the kind is 1 or 2. The count runs down from the reload value and wraps. `pwm_out` is high from reload until the count has passed the match value, which gives a period of reload+1 cycles with match cycles low. With bit 2 set, `pwm_out` stays low.
- R12: Writing ones to address 7 clears the matching flag bits and leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| cap_in | input | 1 | Capture pin, asynchronous |
| trig_in | input | 1 | Start trigger from the previous channel |
| trig_out | output | 1 | One-cycle pulse at each time-out |
| irq_timeout | output | 1 | Sticky time-out flag |
| irq_match | output | 1 | Sticky match flag |
| irq_capture | output | 1 | Sticky capture flag |
| pwm_out | output | 1 | PWM waveform |

## Verification
A register write lands on the edge that samples it, and an enable sets the start value on that same edge. A time-out or match condition seen on the count appears in the flags and on `trig_out` one edge later. A chain trigger delays the first count change by one more edge. A `cap_in` rise takes three edges (two synchroniser stages and the action) to reach the counter or the capture register. The bench drives on falling edges, counts falling edges from the one that ends the enabling write, and samples exactly where these latencies place each result. Where the absolute capture time is not pinned down, it compares two captures a known number of cycles apart.

// File: rtl/gp_timer_chan.sv
module gp_timer_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          cap_in,
  input  logic          trig_in,
  output logic          trig_out,
  output logic          irq_timeout,
  output logic          irq_match,
  output logic          irq_capture,
  output logic          pwm_out
);
  localparam logic [DW-1:0] ONE = 1;

  logic          en, go, trig_q, pwm_q;
  logic [7:0]    mode;
  logic [DW-1:0] rld, mval, cnt, snap, capv;
  logic [2:0]    flg;
  logic          s1, s2, s3;

  wire [1:0] kind   = mode[1:0];
  wire       style  = mode[2];
  wire       alt    = mode[3];
  wire       upc    = mode[4];
  wire       mie    = mode[5];
  wire       wot    = mode[6];
  wire       snp    = mode[7];

  wire pwm_md = alt & ~style & (kind == 2'd1 || kind == 2'd2);
  wire tmr_md = ~pwm_md & (kind == 2'd1 || kind == 2'd2);
  wire cap_md = ~alt & (kind == 2'd3);
  wire run    = en & go;

  wire wr_ctrl = wr_en && wr_addr == 3'd0;
  wire start   = wr_ctrl & wr_data[0] & ~en;
  wire stop_wr = wr_ctrl & ~wr_data[0];

  wire term     = upc ? (cnt == rld) : (cnt == '0);
  wire tmo      = run & tmr_md & term;
  wire mhit     = run & tmr_md & mie & (cnt == mval);
  wire cap_rise = s2 & ~s3;
  wire [DW-1:0] dec = cnt - ONE;
  wire ec_hit   = run & cap_md & ~style & cap_rise & (dec == mval);
  wire et_hit   = run & cap_md & style & cap_rise;

  wire [2:0] clr = (wr_en && wr_addr == 3'd7) ? wr_data[2:0] : 3'b000;
  wire [2:0] set = {ec_hit | et_hit, mhit, tmo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
    end else begin
      s1 <= cap_in; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0;
      go <= 1'b0;
    end else if (wr_ctrl) begin
      en <= wr_data[0];
      go <= wr_data[0] & (en ? go : ~wot);
    end else if (tmo && kind == 2'd1) begin
      en <= 1'b0;
      go <= 1'b0;
    end else if (en && !go && wot && trig_in) begin
      go <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
      rld  <= '0;
      mval <= '0;
    end else if (wr_en) begin
      if (wr_addr == 3'd1 && !en) mode <= wr_data[7:0];
      if (wr_addr == 3'd2) rld  <= wr_data;
      if (wr_addr == 3'd3) mval <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= (tmr_md && upc) ? '0 : rld;
    end else if (run) begin
      if (tmr_md) begin
        if (term) begin
          if (kind == 2'd2) cnt <= upc ? '0 : rld;
        end else begin
          cnt <= upc ? cnt + ONE : dec;
        end
      end else if (pwm_md || (cap_md && style)) begin
        cnt <= (cnt == '0) ? rld : dec;
      end else if (cap_md && cap_rise) begin
        cnt <= (dec == mval) ? rld : dec;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap   <= '0;
      capv   <= '0;
      flg    <= '0;
      trig_q <= 1'b0;
    end else begin
      if (tmo && snp && kind == 2'd2) snap <= cnt;
      if (et_hit) capv <= cnt;
      flg    <= (flg & ~clr) | set;
      trig_q <= tmo;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else if (start) begin
      pwm_q <= pwm_md;
    end else if (!en || stop_wr) begin
      pwm_q <= 1'b0;
    end else if (run && pwm_md) begin
      if (cnt == '0)        pwm_q <= 1'b1;
      else if (cnt == mval) pwm_q <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = {{(DW-1){1'b0}}, en};
      3'd1:    rd_data = {{(DW-8){1'b0}}, mode};
      3'd2:    rd_data = rld;
      3'd3:    rd_data = mval;
      3'd4:    rd_data = (snp && tmr_md && kind == 2'd2) ? snap : cnt;
      3'd5:    rd_data = capv;
      3'd6:    rd_data = {{(DW-3){1'b0}}, flg};
      default: rd_data = '0;
    endcase
  end

  assign trig_out    = trig_q;
  assign irq_timeout = flg[0];
  assign irq_match   = flg[1];
  assign irq_capture = flg[2];
  assign pwm_out     = pwm_q;

  p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(mode));
  p_oneshot_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && kind == 2'd1 && !wr_ctrl) |=> !en);
  p_trig_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> irq_timeout);
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !go && !wr_ctrl) |=> $stable(cnt));
  p_pwm_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_out |-> en);
  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[0] && !tmo) |=> !irq_timeout);
endmodule

// File: tb/gp_timer_chan_test.sv
module gp_timer_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        cap_in = 1'b0, trig_in = 1'b0;
  logic        trig_out, irq_timeout, irq_match, irq_capture, pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gp_timer_chan uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in), .trig_in(trig_in),
    .trig_out(trig_out), .irq_timeout(irq_timeout), .irq_match(irq_match),
    .irq_capture(irq_capture), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic setup(input logic [7:0] m, input logic [31:0] l, input logic [31:0] mt);
    wr(3'd0, 32'h0);
    wr(3'd1, {24'h0, m});
    wr(3'd2, l);
    wr(3'd3, mt);
    wr(3'd7, 32'h7);
  endtask

  task automatic cap_pulse();
    @(negedge clk); cap_in = 1'b1;
    repeat (3) @(negedge clk);
    cap_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      chk("R1 register reads zero", v, 32'h0);
    end
    chk("R1 outputs low", {27'h0, trig_out, pwm_out, irq_timeout, irq_match, irq_capture}, 32'h0);
  endtask

  task automatic t_mode_reg();
    logic [31:0] v;
    wr(3'd1, 32'hFFFF_FF02);
    rd(3'd1, v); chk("R2 upper mode bits zero", v, 32'h0000_0002);
    wr(3'd2, 32'd100);
    wr(3'd0, 32'h1);
    wr(3'd1, 32'h55);
    rd(3'd1, v); chk("R2 mode write while enabled ignored", v, 32'h2);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    setup(8'h01, 32'd5, 32'd1000);
    wr(3'd0, 32'h1);
    repeat (5) @(negedge clk);
    rd(3'd4, v); chk("R3 count reaches zero", v, 32'd0);
    chk("R3 no time-out yet", {31'h0, irq_timeout}, 32'd0);
    @(negedge clk);
    chk("R3 time-out flag set", {31'h0, irq_timeout}, 32'd1);
    chk("R5 trig_out high at time-out", {31'h0, trig_out}, 32'd1);
    rd(3'd0, v); chk("R3 enable cleared", v, 32'd0);
    @(negedge clk);
    chk("R5 trig_out one cycle only", {31'h0, trig_out}, 32'd0);
    rd(3'd4, v); chk("R3 count stays zero", v, 32'd0);
  endtask

  task automatic t_periodic_up();
    logic [31:0] v;
    setup(8'h12, 32'd3, 32'd1000);
    wr(3'd0, 32'h1);
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk("R4 up-count reaches reload", v, 32'd3);
    @(negedge clk);
    rd(3'd4, v); chk("R4 restart at zero", v, 32'd0);
    chk("R4 time-out flag", {31'h0, irq_timeout}, 32'd1);
    chk("R5 pulse at first time-out", {31'h0, trig_out}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R5 no pulse mid-period", {31'h0, trig_out}, 32'd0);
    @(negedge clk);
    chk("R4 second time-out after reload+1 cycles", {31'h0, trig_out}, 32'd1);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_wait_trigger();
    logic [31:0] v;
    setup(8'h41, 32'd4, 32'd1000);
    wr(3'd0, 32'h1);
    repeat (5) @(negedge clk);
    rd(3'd4, v); chk("R6 holds without trigger", v, 32'd4);
    trig_in = 1'b1;
    @(negedge clk);
    trig_in = 1'b0;
    rd(3'd4, v); chk("R6 still held on trigger cycle", v, 32'd4);
    @(negedge clk);
    rd(3'd4, v); chk("R6 counts after trigger", v, 32'd3);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_match();
    setup(8'h22, 32'd10, 32'd6);
    wr(3'd0, 32'h1);
    repeat (4) @(negedge clk);
    chk("R7 match flag not early", {31'h0, irq_match}, 32'd0);
    @(negedge clk);
    chk("R7 match flag set", {31'h0, irq_match}, 32'd1);
    wr(3'd0, 32'h0);
    setup(8'h02, 32'd10, 32'd6);
    wr(3'd0, 32'h1);
    repeat (15) @(negedge clk);
    chk("R7 no match flag without enable bit", {31'h0, irq_match}, 32'd0);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_snapshot();
    logic [31:0] v;
    setup(8'h92, 32'd3, 32'd1000);
    wr(3'd0, 32'h1);
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk("R8 value is snapshot not live", v, 32'd0);
    @(negedge clk);
    rd(3'd4, v); chk("R8 snapshot at time-out", v, 32'd3);
    repeat (2) @(negedge clk);
    rd(3'd4, v); chk("R8 snapshot stable", v, 32'd3);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    setup(8'h22, 32'd4, 32'd2);
    wr(3'd0, 32'h1);
    repeat (8) @(negedge clk);
    wr(3'd0, 32'h0);
    rd(3'd6, v); chk("R12 both flags set first", v & 32'h3, 32'h3);
    wr(3'd7, 32'h1);
    rd(3'd6, v); chk("R12 clear only time-out", v, 32'h2);
  endtask

  task automatic t_edge_count();
    logic [31:0] v;
    setup(8'h03, 32'd5, 32'd2);
    wr(3'd0, 32'h1);
    cap_pulse();
    cap_pulse();
    rd(3'd4, v); chk("R9 two edges counted", v, 32'd3);
    chk("R9 no flag yet", {31'h0, irq_capture}, 32'd0);
    cap_pulse();
    chk("R9 flag at match", {31'h0, irq_capture}, 32'd1);
    rd(3'd4, v); chk("R9 reload after match", v, 32'd5);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_edge_time();
    logic [31:0] c1, c2;
    setup(8'h07, 32'd1000, 32'd0);
    wr(3'd0, 32'h1);
    cap_pulse();
    rd(3'd5, c1);
    chk("R10 capture flag set", {31'h0, irq_capture}, 32'd1);
    cap_pulse();
    rd(3'd5, c2);
    chk("R10 captures differ by edge spacing", c1 - c2, 32'd6);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_pwm();
    int hi;
    setup(8'h0A, 32'd9, 32'd3);
    wr(3'd0, 32'h1);
    repeat (2) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    chk("R11 high cycles over two periods", hi, 32'd14);
    setup(8'h0E, 32'd9, 32'd3);
    wr(3'd0, 32'h1);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    chk("R11 no PWM with capture style set", hi, 32'd0);
    wr(3'd0, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_reg();
    t_oneshot();
    t_periodic_up();
    t_wait_trigger();
    t_match();
    t_snapshot();
    t_clear();
    t_edge_count();
    t_edge_time();
    t_pwm();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule